// File: doc/BRIEF.md
# Two-Wire Controller Status and Interrupt Flag Unit

This block holds the status flags of a two-wire serial controller and turns them into one interrupt line. The frame engine, which is not part of this block, reports single-cycle events: frame start, frame done, byte moved into the shifter, byte landed in the receive holding register, underrun, not-acknowledge and master enable. The register front end reports single-cycle strobes for a status read, a receive holding read and a transmit holding write. Each flag has its own set and clear rules, and some of those rules depend on the state of other flags.

The status word is always visible on `statusFlags`. Any access logic around the block samples it when it issues `rdStatus`. Two set/clear-style writes maintain a per-flag interrupt mask. `irq` is a registered OR of every flag ANDed with its mask bit.

All events and strobes are sampled on the rising clock edge. Their effect is visible on the outputs after that edge.

Top module: `twsf_status_unit`

## Requirements
- R1: While reset is held and after its release with no stimulus, `statusFlags`, `intMask` and `irq` are all zero.
- R2: Transfer-complete (status bit 0) is cleared by `evtFrameStart` and set by `evtFrameDone`, `evtNack` or `evtEnable`. If a set and a clear arrive in the same cycle, the set wins.
- R3: Receive-ready (bit 1) is set by `evtRxLoad` and cleared by `rdRxHold`. If both arrive in the same cycle, the load wins.
- R4: Transmit-ready (bit 2) is cleared by `wrTxHold` and set by `evtTxLoad`, `evtNack` or `evtEnable`. If a write and a set arrive in the same cycle, the write wins and the bit ends at 0.
- R5: Overrun (bit 6) is set when `evtRxLoad` arrives while receive-ready is already 1, judged on its value before that edge.
- R6: Underrun (bit 7) is set by `evtUnderrun`.
- R7: `rdStatus` clears overrun and underrun only while transfer-complete is 1, judged before the edge. A set in the same cycle wins. While transfer-complete is 0, a status read leaves both flags unchanged.
- R8: Not-acknowledge (bit 8) is set by `evtNack` in the same cycle as transfer-complete and transmit-ready. It is cleared by `rdStatus`, and a set in the same cycle wins.
- R9: Each 1 in `wrEnData` with `wrIntEn` sets the mask bit at the same position. Each 1 in `wrDisData` with `wrIntDis` clears it. A 0 bit in either write leaves the mask bit as it was. If both writes touch a bit in one cycle, it ends at 0.
- R10: `irq` is 1 in the cycle after one in which some status bit and the mask bit at the same position are both 1, and 0 otherwise.
- R11: Status and mask bits 3, 4 and 5 always read 0. Mask writes to those positions are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtFrameStart | input | 1 | Frame engine began a frame |
| evtFrameDone | input | 1 | Holding and shifter empty, STOP sent |
| evtTxLoad | input | 1 | Transmit byte moved into the shifter |
| evtRxLoad | input | 1 | Byte written to receive holding register |
| evtUnderrun | input | 1 | Shifter load found no transmit data |
| evtNack | input | 1 | Far end did not acknowledge |
| evtEnable | input | 1 | Master function enabled |
| rdStatus | input | 1 | Status register read strobe |
| rdRxHold | input | 1 | Receive holding register read strobe |
| wrTxHold | input | 1 | Transmit holding register write strobe |
| wrIntEn | input | 1 | Interrupt enable write strobe |
| wrEnData | input | 9 | Bits to set in the mask |
| wrIntDis | input | 1 | Interrupt disable write strobe |
| wrDisData | input | 9 | Bits to clear in the mask |
| statusFlags | output | 9 | Current status word |
| intMask | output | 9 | Current interrupt mask |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its fixed nine-bit layout from the package, because the bit positions are decoded by the register front end. The bench drives random strobes in a dense phase and then a sparse phase. The dense phase makes same-cycle collisions common: load with read, NACK with holding write, enable with disable, and a status read while transfer-complete is low with an error flag pending. The sparse phase lets flags sit long enough for the clear-only and hold-only paths and for the interrupt latency to be seen alone.

// File: rtl/twsf_pkg.sv
package twsf_pkg;
  localparam int FLAG_W   = 9;
  localparam int BIT_DONE = 0;
  localparam int BIT_RXR  = 1;
  localparam int BIT_TXR  = 2;
  localparam int BIT_OVR  = 6;
  localparam int BIT_UNR  = 7;
  localparam int BIT_NAK  = 8;

  // positions that hold real flags; the rest read as zero
  localparam logic [FLAG_W-1:0] IMPL_MASK =
      (FLAG_W'(1) << BIT_DONE) | (FLAG_W'(1) << BIT_RXR) | (FLAG_W'(1) << BIT_TXR) |
      (FLAG_W'(1) << BIT_OVR)  | (FLAG_W'(1) << BIT_UNR) | (FLAG_W'(1) << BIT_NAK);

  // per-bit set/clear strobes; in the datapath, set beats clear
  typedef struct packed {
    logic [FLAG_W-1:0] setVec;
    logic [FLAG_W-1:0] clrVec;
  } flagStrobe_t;
endpackage

// File: rtl/twsf_ctrl.sv
module twsf_ctrl
  import twsf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtFrameStart,
  input  logic              evtFrameDone,
  input  logic              evtTxLoad,
  input  logic              evtRxLoad,
  input  logic              evtUnderrun,
  input  logic              evtNack,
  input  logic              evtEnable,
  input  logic              rdStatus,
  input  logic              rdRxHold,
  input  logic              wrTxHold,
  input  logic [FLAG_W-1:0] flagsQ,
  output flagStrobe_t       strobe
);
  logic errClrOk;
  logic txSetReq;

  assign errClrOk = rdStatus & flagsQ[BIT_DONE];
  assign txSetReq = evtTxLoad | evtNack | evtEnable;

  always_comb begin
    strobe = '0;
    strobe.setVec[BIT_DONE] = evtFrameDone | evtNack | evtEnable;
    strobe.clrVec[BIT_DONE] = evtFrameStart;
    strobe.setVec[BIT_RXR]  = evtRxLoad;
    strobe.clrVec[BIT_RXR]  = rdRxHold;
    // a holding write in the same cycle wins over any set
    strobe.setVec[BIT_TXR]  = txSetReq & ~wrTxHold;
    strobe.clrVec[BIT_TXR]  = wrTxHold;
    strobe.setVec[BIT_OVR]  = evtRxLoad & flagsQ[BIT_RXR];
    strobe.clrVec[BIT_OVR]  = errClrOk;
    strobe.setVec[BIT_UNR]  = evtUnderrun;
    strobe.clrVec[BIT_UNR]  = errClrOk;
    strobe.setVec[BIT_NAK]  = evtNack;
    strobe.clrVec[BIT_NAK]  = rdStatus;
  end

  assert_done_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    (evtFrameStart && !evtFrameDone && !evtNack && !evtEnable) |=> !flagsQ[BIT_DONE]);
  assert_rx_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    evtRxLoad |=> flagsQ[BIT_RXR]);
  assert_tx_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrTxHold |=> !flagsQ[BIT_TXR]);
  assert_overrun_R5: assert property (@(posedge clk) disable iff (!rstN)
    (evtRxLoad && flagsQ[BIT_RXR]) |=> flagsQ[BIT_OVR]);
  assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdStatus && !flagsQ[BIT_DONE] && flagsQ[BIT_UNR]) |=> flagsQ[BIT_UNR]);
  assert_nack_trio_R8: assert property (@(posedge clk) disable iff (!rstN)
    (evtNack && !wrTxHold) |=> (flagsQ[BIT_NAK] && flagsQ[BIT_DONE] && flagsQ[BIT_TXR]));
  assert_unused_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (flagsQ & ~IMPL_MASK) == '0);
endmodule

// File: rtl/twsf_datapath.sv
module twsf_datapath
  import twsf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  flagStrobe_t       strobe,
  input  logic              wrIntEn,
  input  logic [FLAG_W-1:0] wrEnData,
  input  logic              wrIntDis,
  input  logic [FLAG_W-1:0] wrDisData,
  output logic [FLAG_W-1:0] flagsQ,
  output logic [FLAG_W-1:0] maskQ,
  output logic              irqQ
);
  logic [FLAG_W-1:0] enBits;
  logic [FLAG_W-1:0] disBits;

  assign enBits  = wrIntEn  ? wrEnData  : '0;
  assign disBits = wrIntDis ? wrDisData : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsQ <= '0;
      maskQ  <= '0;
      irqQ   <= 1'b0;
    end else begin
      flagsQ <= ((flagsQ & ~strobe.clrVec) | strobe.setVec) & IMPL_MASK;
      maskQ  <= (maskQ | enBits) & ~disBits & IMPL_MASK;
      irqQ   <= |(flagsQ & maskQ);
    end
  end

  assert_mask_dis_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrIntDis |=> (maskQ & $past(wrDisData)) == '0);
  assert_mask_en_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrIntEn && !wrIntDis) |=> (maskQ & $past(wrEnData & IMPL_MASK)) == $past(wrEnData & IMPL_MASK));
  assert_mask_unused_R11: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ & ~IMPL_MASK) == '0);
endmodule

// File: rtl/twsf_status_unit.sv
module twsf_status_unit
  import twsf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtFrameStart,
  input  logic              evtFrameDone,
  input  logic              evtTxLoad,
  input  logic              evtRxLoad,
  input  logic              evtUnderrun,
  input  logic              evtNack,
  input  logic              evtEnable,
  input  logic              rdStatus,
  input  logic              rdRxHold,
  input  logic              wrTxHold,
  input  logic              wrIntEn,
  input  logic [FLAG_W-1:0] wrEnData,
  input  logic              wrIntDis,
  input  logic [FLAG_W-1:0] wrDisData,
  output logic [FLAG_W-1:0] statusFlags,
  output logic [FLAG_W-1:0] intMask,
  output logic              irq
);
  flagStrobe_t       strobe;
  logic [FLAG_W-1:0] flagsQ;

  twsf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .evtFrameStart(evtFrameStart), .evtFrameDone(evtFrameDone),
    .evtTxLoad(evtTxLoad), .evtRxLoad(evtRxLoad),
    .evtUnderrun(evtUnderrun), .evtNack(evtNack), .evtEnable(evtEnable),
    .rdStatus(rdStatus), .rdRxHold(rdRxHold), .wrTxHold(wrTxHold),
    .flagsQ(flagsQ), .strobe(strobe)
  );

  twsf_datapath u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrIntEn(wrIntEn), .wrEnData(wrEnData),
    .wrIntDis(wrIntDis), .wrDisData(wrDisData),
    .flagsQ(flagsQ), .maskQ(intMask), .irqQ(irq)
  );

  assign statusFlags = flagsQ;
endmodule

// File: tb/twsf_status_unit_bench.sv
`timescale 1ns/100ps
module twsf_status_unit_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evtFrameStart = 0, evtFrameDone = 0, evtTxLoad = 0, evtRxLoad = 0;
  logic evtUnderrun = 0, evtNack = 0, evtEnable = 0;
  logic rdStatus = 0, rdRxHold = 0, wrTxHold = 0, wrIntEn = 0, wrIntDis = 0;
  logic [8:0] wrEnData = '0, wrDisData = '0;
  logic [8:0] statusFlags, intMask;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  bit mDone, mRx, mTx, mOvr, mUnr, mNak, mIrq;
  bit [8:0] mMask;
  bit nDone, nRx, nTx, nOvr, nUnr, nNak, nIrq;
  bit [8:0] nMask;

  always #2.5 clk = ~clk;

  twsf_status_unit u_twsf_status_unit (
    .clk(clk), .rstN(rstN),
    .evtFrameStart(evtFrameStart), .evtFrameDone(evtFrameDone),
    .evtTxLoad(evtTxLoad), .evtRxLoad(evtRxLoad), .evtUnderrun(evtUnderrun),
    .evtNack(evtNack), .evtEnable(evtEnable),
    .rdStatus(rdStatus), .rdRxHold(rdRxHold), .wrTxHold(wrTxHold),
    .wrIntEn(wrIntEn), .wrEnData(wrEnData), .wrIntDis(wrIntDis), .wrDisData(wrDisData),
    .statusFlags(statusFlags), .intMask(intMask), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit [8:0] modelStatus();
    bit [8:0] s = '0;
    s[0] = mDone; s[1] = mRx; s[2] = mTx; s[6] = mOvr; s[7] = mUnr; s[8] = mNak;
    return s;
  endfunction

  task automatic compareAll();
    chk("R2 transfer-complete bit0", int'(statusFlags[0]), int'(mDone));
    chk("R3 receive-ready bit1",     int'(statusFlags[1]), int'(mRx));
    chk("R4 transmit-ready bit2",    int'(statusFlags[2]), int'(mTx));
    chk("R5/R7 overrun bit6",        int'(statusFlags[6]), int'(mOvr));
    chk("R6/R7 underrun bit7",       int'(statusFlags[7]), int'(mUnr));
    chk("R8 nack bit8",              int'(statusFlags[8]), int'(mNak));
    chk("R9 mask",                   int'(intMask), int'(mMask));
    chk("R10 irq",                   int'(irq), int'(mIrq));
    chk("R11 status bits 5:3",       int'(statusFlags[5:3]), 0);
    chk("R11 mask bits 5:3",         int'(intMask[5:3]), 0);
  endtask

  // next state from the requirements, given current model and the driven inputs
  task automatic computeNext();
    bit [8:0] st = modelStatus();
    nDone = (evtFrameDone || evtNack || evtEnable) ? 1'b1 : (evtFrameStart ? 1'b0 : mDone);
    nRx   = evtRxLoad ? 1'b1 : (rdRxHold ? 1'b0 : mRx);
    nTx   = wrTxHold ? 1'b0 : ((evtTxLoad || evtNack || evtEnable) ? 1'b1 : mTx);
    nOvr  = (evtRxLoad && mRx) ? 1'b1 : ((rdStatus && mDone) ? 1'b0 : mOvr);
    nUnr  = evtUnderrun ? 1'b1 : ((rdStatus && mDone) ? 1'b0 : mUnr);
    nNak  = evtNack ? 1'b1 : (rdStatus ? 1'b0 : mNak);
    foreach (nMask[i]) begin
      if (i >= 3 && i <= 5) nMask[i] = 1'b0;
      else if (wrIntDis && wrDisData[i]) nMask[i] = 1'b0;
      else if (wrIntEn && wrEnData[i]) nMask[i] = 1'b1;
      else nMask[i] = mMask[i];
    end
    nIrq = |(st & mMask);
  endtask

  task automatic applyNext();
    mDone = nDone; mRx = nRx; mTx = nTx; mOvr = nOvr; mUnr = nUnr; mNak = nNak;
    mMask = nMask; mIrq = nIrq;
  endtask

  task automatic driveRandom(input int den);
    evtFrameStart = ($urandom_range(0, den) == 0);
    evtFrameDone  = ($urandom_range(0, den) == 0);
    evtTxLoad     = ($urandom_range(0, den) == 0);
    evtRxLoad     = ($urandom_range(0, den) == 0);
    evtUnderrun   = ($urandom_range(0, den) == 0);
    evtNack       = ($urandom_range(0, den) == 0);
    evtEnable     = ($urandom_range(0, den) == 0);
    rdStatus      = ($urandom_range(0, den) == 0);
    rdRxHold      = ($urandom_range(0, den) == 0);
    wrTxHold      = ($urandom_range(0, den) == 0);
    wrIntEn       = ($urandom_range(0, den) == 0);
    wrIntDis      = ($urandom_range(0, den) == 0);
    wrEnData      = 9'($urandom);
    wrDisData     = 9'($urandom);
  endtask

  task automatic runPhase(input int cycles, input int den);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      applyNext();
      compareAll();
      driveRandom(den);
      computeNext();
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    mDone = 0; mRx = 0; mTx = 0; mOvr = 0; mUnr = 0; mNak = 0; mIrq = 0; mMask = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset status", int'(statusFlags), 0);
    chk("R1 reset mask",   int'(intMask), 0);
    chk("R1 reset irq",    int'(irq), 0);
    @(negedge clk);
    rstN = 1'b1;
    computeNext();
    runPhase(4, 1000000);
    chk("R1 idle after reset", int'(statusFlags), 0);
    runPhase(6000, 3);
    runPhase(6000, 12);
    runPhase(20, 1000000);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 50000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule